// File: doc/BRIEF.md
# Tile-Triggered Character Bank Switcher

This block sits on a game cartridge between the console's two buses. On the video side it watches the pattern fetches of the picture processor. It replaces the upper address bits of the character ROM on its own, and it does so whenever the processor fetches one of two marker tiles. The pattern space has two 4 KiB halves. For each half, the CPU stores two bank numbers in advance: one for marker tile $FD and one for marker tile $FE. A one-bit selector per half records which marker that half saw last. Graphics can therefore change bank part way through a scanline with no CPU work at that moment.

On the CPU side the block banks the 32 KiB program window. One 8 KiB slot can be switched, and the other three slots always show the last three 8 KiB banks of the program ROM. The CPU can also set a nametable mirroring bit. Every register is written with a store anywhere in a 4 KiB region of the upper half of the CPU map. Outputs are combinational from the CPU and video addresses and the internal state. State changes take effect at the clock edge that samples a write or a fetch.

Top module: `tile_bank_mapper`

## Requirements
- R1: After reset the program bank register, all four character bank registers and the mirroring bit are 0, and both half selectors point at their $FE bank register.
- R2: `prg_hi` depends on `cpu_addr[14:13]`. Slot 0 ($8000-$9FFF) gives the program bank register. Slots 1, 2 and 3 give the constants 2^PRG_BANK_W-3, 2^PRG_BANK_W-2 and 2^PRG_BANK_W-1.
- R3: A write is decoded from `cpu_addr[15:12]`. $A selects the program bank, $B the low-half $FD bank and $C the low-half $FE bank. $D selects the high-half $FD bank and $E the high-half $FE bank. Writes to $8, $9 or to any address below $8000 change nothing.
- R4: A write to $Fxxx sets the mirroring bit from `cpu_wdata[0]` (0 vertical, 1 horizontal), and the other data bits are ignored.
- R5: `chr_hi` is the bank register chosen by the selector of the half given by `ppu_addr[12]`: the $FD register when that selector is 0, the $FE register when it is 1.
- R6: A read strobe at $0FD8-$0FDF sets the low selector to $FD. A read strobe at $1FD8-$1FDF sets the high selector to $FD.
- R7: A read strobe at $0FE8-$0FEF sets the low selector to $FE. A read strobe at $1FE8-$1FEF sets the high selector to $FE.
- R8: The fetch that triggers a switch is itself served from the old bank. The new bank applies from the next clock.
- R9: No selector changes in three cases: when `ppu_rd` is low, for the first-plane addresses $xFD0-$xFD7 and $xFE0-$xFE7, and when `ppu_addr[13]` is 1.
- R10: Rewriting a bank register while its half points at it changes `chr_hi` from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | Video address bus |
| ppu_rd | input | 1 | Video read strobe |
| prg_hi | output | PRG_BANK_W | Program ROM upper address bits |
| chr_hi | output | CHR_BANK_W | Character ROM upper address bits (4 KiB banks) |
| mirror_h | output | 1 | Mirroring select, 1 horizontal |

## Verification
The assertions assume three things about the inputs. Each CPU store raises `cpu_we` for exactly one sampled clock. The video address is stable while `ppu_rd` is sampled high. Nothing other than reset changes a selector between fetches. The random stimulus is applied on the falling edge and held for a full clock. It forms video addresses so that about half of them land in the marker-tile rows, including first-plane rows and nametable-space copies. CPU writes fall anywhere in the 64 KiB map, so decoded regions and ignored regions are both hit often.

// File: rtl/tile_bank_mapper.sv
module tile_bank_mapper #(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_we,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_wdata,
  input  logic [13:0]           ppu_addr,
  input  logic                  ppu_rd,
  output logic [PRG_BANK_W-1:0] prg_hi,
  output logic [CHR_BANK_W-1:0] chr_hi,
  output logic                  mirror_h
);
  localparam logic [PRG_BANK_W-1:0] LAST = '1;

  logic [PRG_BANK_W-1:0] prg_reg;
  logic [CHR_BANK_W-1:0] lo_fd, lo_fe, hi_fd, hi_fe;
  logic                  latch_lo, latch_hi;

  logic       reg_wr;
  logic       tile_hit;
  logic [7:0] tile_no;

  assign reg_wr   = cpu_we && cpu_addr[15];
  assign tile_no  = ppu_addr[11:4];
  assign tile_hit = ppu_rd && !ppu_addr[13] && ppu_addr[3] &&
                    (tile_no == 8'hFD || tile_no == 8'hFE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_reg  <= '0;
      lo_fd    <= '0;
      lo_fe    <= '0;
      hi_fd    <= '0;
      hi_fe    <= '0;
      mirror_h <= 1'b0;
    end else if (reg_wr) begin
      case (cpu_addr[14:12])
        3'd2: prg_reg  <= cpu_wdata[PRG_BANK_W-1:0];
        3'd3: lo_fd    <= cpu_wdata[CHR_BANK_W-1:0];
        3'd4: lo_fe    <= cpu_wdata[CHR_BANK_W-1:0];
        3'd5: hi_fd    <= cpu_wdata[CHR_BANK_W-1:0];
        3'd6: hi_fe    <= cpu_wdata[CHR_BANK_W-1:0];
        3'd7: mirror_h <= cpu_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_lo <= 1'b1;
      latch_hi <= 1'b1;
    end else if (tile_hit) begin
      if (ppu_addr[12]) latch_hi <= ~ppu_addr[4];
      else              latch_lo <= ~ppu_addr[4];
    end
  end

  always_comb begin
    case (cpu_addr[14:13])
      2'd0:    prg_hi = prg_reg;
      2'd1:    prg_hi = LAST - PRG_BANK_W'(2);
      2'd2:    prg_hi = LAST - PRG_BANK_W'(1);
      default: prg_hi = LAST;
    endcase
  end

  assign chr_hi = ppu_addr[12] ? (latch_hi ? hi_fe : hi_fd)
                               : (latch_lo ? lo_fe : lo_fd);
endmodule

// File: rtl/tile_bank_mapper_chk.sv
module tile_bank_mapper_chk #(
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_we,
  input logic [15:0]           cpu_addr,
  input logic [7:0]            cpu_wdata,
  input logic [13:0]           ppu_addr,
  input logic                  ppu_rd,
  input logic [PRG_BANK_W-1:0] prg_hi,
  input logic [CHR_BANK_W-1:0] chr_hi,
  input logic                  mirror_h,
  input logic [PRG_BANK_W-1:0] prg_reg,
  input logic                  latch_lo,
  input logic                  latch_hi
);
  p_prg_top_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[14:13] == 2'b11 |-> prg_hi == {PRG_BANK_W{1'b1}});

  p_prg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_addr[15:12] == 4'hA) |=> $stable(prg_reg));

  p_mirror_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && cpu_addr[15:12] == 4'hF |=> mirror_h == $past(cpu_wdata[0]));

  p_lo_fd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_rd && ppu_addr[13:3] == {2'b00, 8'hFD, 1'b1} |=> !latch_lo);

  p_hi_fe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_rd && ppu_addr[13:3] == {2'b01, 8'hFE, 1'b1} |=> latch_hi);

  p_idle_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_rd |=> $stable(latch_lo) && $stable(latch_hi));

  p_name_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_addr[13] |=> $stable(latch_lo) && $stable(latch_hi));
endmodule

bind tile_bank_mapper tile_bank_mapper_chk #(
  .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)
) u_chk (.*);

// File: tb/sim_tile_bank_mapper.sv
`timescale 1ns/1ps
module sim_tile_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0;
  logic [3:0]  prg_hi;
  logic [4:0]  chr_hi;
  logic        mirror_h;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_prg;
  logic [4:0] m_bank [4];
  logic       m_mir, m_lo, m_hi;

  always #4 clk = ~clk;

  tile_bank_mapper u0 (.*);

  function automatic logic [3:0] exp_prg(logic [15:0] a);
    case (a[14:13])
      2'd0: return m_prg;
      2'd1: return 4'd13;
      2'd2: return 4'd14;
      default: return 4'd15;
    endcase
  endfunction

  function automatic logic [4:0] exp_chr(logic [13:0] a);
    if (a[12]) return m_hi ? m_bank[3] : m_bank[2];
    return m_lo ? m_bank[1] : m_bank[0];
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_prg = '0; m_mir = 1'b0; m_lo = 1'b1; m_hi = 1'b1;
    for (int i = 0; i < 4; i++) m_bank[i] = '0;
  endtask

  task automatic cycle(string tag, logic we, logic [15:0] ca, logic [7:0] wd,
                       logic [13:0] pa, logic rd);
    @(negedge clk);
    cpu_we = we; cpu_addr = ca; cpu_wdata = wd; ppu_addr = pa; ppu_rd = rd;
    #1;
    chk(tag, "prg_hi", prg_hi, exp_prg(ca));
    chk(tag, "chr_hi", chr_hi, exp_chr(pa));
    chk(tag, "mirror_h", mirror_h, m_mir);
    if (we && ca[15]) begin
      case (ca[14:12])
        3'd2: m_prg = wd[3:0];
        3'd3: m_bank[0] = wd[4:0];
        3'd4: m_bank[1] = wd[4:0];
        3'd5: m_bank[2] = wd[4:0];
        3'd6: m_bank[3] = wd[4:0];
        3'd7: m_mir = wd[0];
        default: ;
      endcase
    end
    if (rd && !pa[13] && pa[3] && (pa[11:4] == 8'hFD || pa[11:4] == 8'hFE)) begin
      if (pa[12]) m_hi = (pa[11:4] == 8'hFE);
      else        m_lo = (pa[11:4] == 8'hFE);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cycle("R1", 0, 16'h8000, 0, 14'h0000, 0);
    cycle("R3", 1, 16'hB000, 8'd3, 14'h0000, 0);
    cycle("R3", 1, 16'hC000, 8'd7, 14'h0000, 0);
    cycle("R3", 1, 16'hD123, 8'd9, 14'h0000, 0);
    cycle("R3", 1, 16'hEFFF, 8'd12, 14'h1000, 0);
    cycle("R1", 0, 16'h8000, 0, 14'h0010, 1);
    cycle("R1", 0, 16'h8000, 0, 14'h1010, 1);
    cycle("R8", 0, 16'h8000, 0, 14'h0FD8, 1);
    cycle("R6", 0, 16'h8000, 0, 14'h0000, 1);
    cycle("R8", 0, 16'h8000, 0, 14'h1FDF, 1);
    cycle("R6", 0, 16'h8000, 0, 14'h1000, 1);
    cycle("R9", 0, 16'h8000, 0, 14'h0FE0, 1);
    cycle("R9", 0, 16'h8000, 0, 14'h0FE8, 0);
    cycle("R9", 0, 16'h8000, 0, 14'h2FE8, 1);
    cycle("R9", 0, 16'h8000, 0, 14'h0000, 1);
    cycle("R7", 0, 16'h8000, 0, 14'h0FEF, 1);
    cycle("R7", 0, 16'h8000, 0, 14'h1FE8, 1);
    cycle("R7", 0, 16'h8000, 0, 14'h0000, 1);
    cycle("R10", 1, 16'hC000, 8'd20, 14'h0000, 1);
    cycle("R10", 0, 16'h8000, 0, 14'h0000, 1);
    cycle("R3", 1, 16'hA000, 8'd5, 14'h0000, 0);
    cycle("R3", 1, 16'h9000, 8'd11, 14'h0000, 0);
    cycle("R3", 1, 16'h8000, 8'd11, 14'h0000, 0);
    cycle("R3", 1, 16'h2000, 8'd11, 14'h0000, 0);
    cycle("R2", 0, 16'h8000, 0, 14'h0000, 0);
    cycle("R2", 0, 16'hA000, 0, 14'h0000, 0);
    cycle("R2", 0, 16'hC000, 0, 14'h0000, 0);
    cycle("R2", 0, 16'hFFFC, 0, 14'h0000, 0);
    cycle("R4", 1, 16'hF000, 8'hFE, 14'h0000, 0);
    cycle("R4", 1, 16'hF000, 8'h01, 14'h0000, 0);
    cycle("R4", 0, 16'h8000, 0, 14'h0000, 0);

    for (int n = 0; n < 4000; n++) begin
      logic        we;
      logic [15:0] ca;
      logic [13:0] pa;
      we = ($urandom % 4) == 0;
      ca = 16'($urandom);
      if ($urandom % 2)
        pa = {1'($urandom), 1'($urandom), 4'hF,
              (($urandom % 2) ? 4'hD : 4'hE), 4'($urandom)};
      else
        pa = 14'($urandom);
      cycle("R5", we, ca, 8'($urandom), pa, ($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule